// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

This block is an on-chip, synthesizable model of a flow-through synchronous SRAM built so that reads and writes can follow each other on consecutive clocks with no idle cycle in between. Address, cycle type and byte enables are registered on a clock edge. Read data is driven combinationally from that registered address during the next cycle. The data for a write is taken one edge after its address. It then waits in a pending register and is committed to the array on the following enabled edge. A read of a location whose newest bytes still sit in that pending register receives those bytes directly.

A load/advance strobe either starts a new access or continues the current one. Each continuation steps a 2-bit burst counter that produces the next address, either in linear order or in interleaved order. A stall input freezes the whole block for a cycle. A sleep request blocks new commands and is acknowledged only once no write remains in flight.

Top module: `zbt_sram_core`

## Requirements
- R1: After reset, `rdValid` and `sleepAck` are 0, and every array word reads as zero.
- R2: On an enabled edge with `loadN`=0 and `sel`=1, `readNotWrite`=1 starts a read of `addr` and 0 starts a write. For a read, while `outEn`=1, `rdValid`=1 and `rdData` holds the word during the cycle after that edge.
- R3: The data for a write cycle is sampled on the next enabled edge. Byte lane k (bits 8k+7..8k) is written only if `byteWe[k]`=1. A write with `byteWe`=0 leaves the word unchanged.
- R4: A read returns the newest data, including bytes that are still held in the pending write register and not yet committed.
- R5: With `loadN`=1, an active access continues as a burst of the same type. With `burstInterleave`=0, the low 2 address bits are start+count modulo 4. The address wraps to the start after four beats, and the upper address bits never change.
- R6: With `burstInterleave`=1, the low 2 address bits of a burst are start XOR count.
- R7: An edge with `stall`=1 is ignored: no address, count, cycle type, pending write or sleep state changes.
- R8: `rdValid`=0 and `rdData`=0 whenever `outEn`=0 or no read is active. A burst continues even while the output is disabled.
- R9: A deselect cycle (`loadN`=0, `sel`=0) ends any burst, so later advance cycles do nothing. A write pending at the deselect still completes.
- R10: While `sleepReq`=1, new commands are ignored. `sleepAck` rises only on an edge at which no write address and no pending data remain. Commands resume once `sleepReq`=0 and `sleepAck` has fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous active-low reset |
| stall | input | 1 | 1 = ignore this clock edge |
| sel | input | 1 | Chip select, sampled when `loadN`=0 |
| loadN | input | 1 | 0 = load a new access, 1 = advance the burst |
| readNotWrite | input | 1 | 1 = read, 0 = write (on load cycles) |
| byteWe | input | BYTES | Per-lane write enables |
| addr | input | ADDR_W | Word address |
| wrData | input | DATA_W | Write data, one edge after its address |
| outEn | input | 1 | 1 = output data enabled |
| burstInterleave | input | 1 | 1 = interleaved burst order, 0 = linear |
| sleepReq | input | 1 | Request to enter sleep |
| rdData | output | DATA_W | Flow-through read data, zero when not valid |
| rdValid | output | 1 | Read data is driven |
| sleepAck | output | 1 | Sleep entered |

## Verification
The main function is tried with three kinds of pattern. A write followed at once by a read of the same address separates forwarding from the pending register from a plain array read. Partial and zero byte-enable writes separate lane merging from whole-word writes. Four-beat write bursts read back in linear order and then in interleaved order from an odd start: the resulting address sequences differ at every other beat, so a mixed-up order rule shows up. Stall, output-disable and deselect cycles inside a burst are each followed by a further advance, whose address shows whether the counter moved when it should not have.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic edgeEn;   // this edge is not stalled
    logic capWr;    // sample write data on this edge
    logic rdOut;    // drive read data this cycle
  } strobe_t;

endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              stall,
  input  logic              sel,
  input  logic              loadN,
  input  logic              readNotWrite,
  input  logic [BYTES-1:0]  byteWe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              outEn,
  input  logic              burstInterleave,
  input  logic              sleepReq,
  input  logic              pendValid,
  output strobe_t           strobes,
  output logic [ADDR_W-1:0] curAddr,
  output logic [BYTES-1:0]  curBe,
  output op_e               curOp,
  output logic              sleepAck
);

  logic [ADDR_W-1:0] addrQ;
  logic [CNT_W-1:0]  baseQ;
  logic [CNT_W-1:0]  cntQ;
  logic [BYTES-1:0]  beQ;
  op_e               opQ;
  logic              sleepQ;

  logic              edgeEn;
  logic              blocked;
  logic [CNT_W-1:0]  cntNext;
  logic [CNT_W-1:0]  lowNext;

  assign edgeEn  = !stall;
  assign blocked = sleepReq || sleepQ;
  assign cntNext = cntQ + 1'b1;

  // burst address order
  always_comb begin
    if (burstInterleave) lowNext = baseQ ^ cntNext;
    else                 lowNext = baseQ + cntNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      baseQ  <= '0;
      cntQ   <= '0;
      beQ    <= '0;
      opQ    <= OP_IDLE;
      sleepQ <= 1'b0;
    end else if (edgeEn) begin
      if (!loadN) begin
        if (sel && !blocked) begin
          opQ   <= readNotWrite ? OP_READ : OP_WRITE;
          addrQ <= addr;
          baseQ <= addr[CNT_W-1:0];
          cntQ  <= '0;
          beQ   <= byteWe;
        end else begin
          opQ <= OP_IDLE;
        end
      end else if (blocked) begin
        opQ <= OP_IDLE;
      end else if (opQ != OP_IDLE) begin
        cntQ                <= cntNext;
        addrQ[CNT_W-1:0]    <= lowNext;
        beQ                 <= byteWe;
      end
      sleepQ <= sleepReq && (opQ != OP_WRITE) && !pendValid;
    end
  end

  always_comb begin
    strobes.edgeEn = edgeEn;
    strobes.capWr  = edgeEn && (opQ == OP_WRITE);
    strobes.rdOut  = (opQ == OP_READ) && outEn && !sleepQ;
  end

  assign curAddr  = addrQ;
  assign curBe    = beQ;
  assign curOp    = opQ;
  assign sleepAck = sleepQ;

endmodule

// File: rtl/zbt_datapath.sv
module zbt_datapath
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobes,
  input  logic [ADDR_W-1:0]       curAddr,
  input  logic [BYTES-1:0]        curBe,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  output logic                    pendValid,
  output logic [BYTES*BYTE_W-1:0] rdData
);

  localparam int DATA_W = BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] pendAddr;
  logic [BYTES-1:0]  pendBe;
  logic [DATA_W-1:0] pendData;
  logic [DATA_W-1:0] arrWord;
  logic [DATA_W-1:0] mergedWord;
  logic              hit;

  // late-write register and array commit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendAddr  <= '0;
      pendBe    <= '0;
      pendData  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobes.edgeEn) begin
      if (pendValid) begin
        for (int b = 0; b < BYTES; b++) begin
          if (pendBe[b]) mem[pendAddr][b*BYTE_W +: BYTE_W] <= pendData[b*BYTE_W +: BYTE_W];
        end
      end
      pendValid <= strobes.capWr;
      if (strobes.capWr) begin
        pendAddr <= curAddr;
        pendBe   <= curBe;
        pendData <= wrData;
      end
    end
  end

  assign arrWord = mem[curAddr];
  assign hit     = pendValid && (pendAddr == curAddr);

  // read bypass per byte lane
  for (genvar g = 0; g < BYTES; g++) begin : gLane
    assign mergedWord[g*BYTE_W +: BYTE_W] =
      (hit && pendBe[g]) ? pendData[g*BYTE_W +: BYTE_W] : arrWord[g*BYTE_W +: BYTE_W];
  end

  assign rdData = strobes.rdOut ? mergedWord : '0;

endmodule

// File: rtl/zbt_sram_core.sv
module zbt_sram_core
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stall,
  input  logic                    sel,
  input  logic                    loadN,
  input  logic                    readNotWrite,
  input  logic [BYTES-1:0]        byteWe,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [BYTES*BYTE_W-1:0] wrData,
  input  logic                    outEn,
  input  logic                    burstInterleave,
  input  logic                    sleepReq,
  output logic [BYTES*BYTE_W-1:0] rdData,
  output logic                    rdValid,
  output logic                    sleepAck
);

  strobe_t           strobes;
  logic [ADDR_W-1:0] curAddr;
  logic [BYTES-1:0]  curBe;
  op_e               curOp;
  logic              pendValid;

  zbt_ctrl #(.ADDR_W(ADDR_W), .BYTES(BYTES), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .stall(stall), .sel(sel), .loadN(loadN),
    .readNotWrite(readNotWrite), .byteWe(byteWe), .addr(addr), .outEn(outEn),
    .burstInterleave(burstInterleave), .sleepReq(sleepReq), .pendValid(pendValid),
    .strobes(strobes), .curAddr(curAddr), .curBe(curBe), .curOp(curOp),
    .sleepAck(sleepAck)
  );

  zbt_datapath #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curAddr(curAddr), .curBe(curBe),
    .wrData(wrData), .pendValid(pendValid), .rdData(rdData)
  );

  assign rdValid = strobes.rdOut;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk
  import zbt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic              loadN,
  input logic              outEn,
  input logic              sleepAck,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] curAddr,
  input op_e               curOp,
  input logic              pendValid
);

  // R7
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(curAddr) && $stable(pendValid) && $stable(curOp) && $stable(sleepAck)));

  // R10
  sleep_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepAck |-> !pendValid);

  // R8
  out_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (outEn && !sleepAck));

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // R5
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> (curAddr[ADDR_W-1:CNT_W] == $past(curAddr[ADDR_W-1:CNT_W])));

  // R3
  late_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stall && curOp == OP_WRITE) |=> pendValid);

endmodule

bind zbt_sram_core zbt_sram_chk #(.ADDR_W(ADDR_W), .DATA_W(BYTES*BYTE_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .stall(stall), .loadN(loadN), .outEn(outEn),
  .sleepAck(sleepAck), .rdValid(rdValid), .rdData(rdData), .curAddr(curAddr),
  .curOp(curOp), .pendValid(pendValid)
);

// File: tb/zbt_sram_core_tb.sv
`timescale 1ns/1ps
module zbt_sram_core_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        stall = 1'b0, sel = 1'b0, loadN = 1'b0, readNotWrite = 1'b1;
  logic [1:0]  byteWe = 2'b00;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wrData = 16'h0000;
  logic        outEn = 1'b1, burstInterleave = 1'b0, sleepReq = 1'b0;
  logic [15:0] rdData;
  logic        rdValid, sleepAck;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  zbt_sram_core dut_i (
    .clk(clk), .rstN(rstN), .stall(stall), .sel(sel), .loadN(loadN),
    .readNotWrite(readNotWrite), .byteWe(byteWe), .addr(addr), .wrData(wrData),
    .outEn(outEn), .burstInterleave(burstInterleave), .sleepReq(sleepReq),
    .rdData(rdData), .rdValid(rdValid), .sleepAck(sleepAck)
  );

  typedef struct packed {
    logic        st;
    logic        se;
    logic        ld;
    logic        rw;
    logic [1:0]  be;
    logic [7:0]  ad;
    logic [15:0] wd;
    logic        oe;
    logic        il;
    logic        ev;
    logic [15:0] ed;
  } vec_t;

  // fields: stall sel loadN rnw be addr wrData outEn ilv | expValid expData
  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,2'b11,8'h10,16'h0000,1'b1,1'b0, 1'b0,16'h0000}, // R2 write 0x10
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h10,16'hA1B2,1'b1,1'b0, 1'b1,16'hA1B2}, // R4 forward
    '{1'b0,1'b1,1'b0,1'b0,2'b01,8'h11,16'h0000,1'b1,1'b0, 1'b0,16'h0000}, // R3 low lane
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h10,16'hFFEE,1'b1,1'b0, 1'b1,16'hA1B2}, // R2 array read
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h11,16'h0000,1'b1,1'b0, 1'b1,16'h00EE}, // R3 partial
    '{1'b0,1'b1,1'b0,1'b0,2'b00,8'h12,16'h0000,1'b1,1'b0, 1'b0,16'h0000}, // R3 abort
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h12,16'h5555,1'b1,1'b0, 1'b1,16'h0000}, // R3 abort
    '{1'b0,1'b1,1'b0,1'b0,2'b11,8'h21,16'h0000,1'b1,1'b0, 1'b0,16'h0000}, // R5 burst write
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,16'h1111,1'b1,1'b0, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,16'h2222,1'b1,1'b0, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,16'h3333,1'b1,1'b0, 1'b0,16'h0000},
    '{1'b0,1'b0,1'b1,1'b0,2'b11,8'h00,16'h4444,1'b1,1'b0, 1'b0,16'h0000}, // R5 wrap
    '{1'b0,1'b0,1'b0,1'b1,2'b00,8'h00,16'h5555,1'b1,1'b0, 1'b0,16'h0000}, // R9 deselect
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h20,16'h0000,1'b1,1'b0, 1'b1,16'h4444}, // R5 linear
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b1,16'h5555}, // R9 completed
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b1,16'h2222},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b1,16'h3333},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b1,16'h4444}, // R5 wrap
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h21,16'h0000,1'b1,1'b1, 1'b1,16'h5555}, // R6 interleave
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b1, 1'b1,16'h4444},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b1, 1'b1,16'h3333},
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b1, 1'b1,16'h2222},
    '{1'b0,1'b1,1'b0,1'b1,2'b00,8'h20,16'h0000,1'b0,1'b0, 1'b0,16'h0000}, // R8 oe off
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b1,16'h5555}, // R8 burst kept
    '{1'b1,1'b1,1'b0,1'b1,2'b00,8'h23,16'h0000,1'b1,1'b0, 1'b1,16'h5555}, // R7 stall
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b1,16'h2222}, // R7 no step
    '{1'b0,1'b0,1'b0,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b0,16'h0000}, // R9 deselect
    '{1'b0,1'b0,1'b1,1'b1,2'b00,8'h00,16'h0000,1'b1,1'b0, 1'b0,16'h0000}  // R9 ended
  };

  task automatic cyc(input logic st, input logic se, input logic ld, input logic rw,
                     input logic [1:0] be, input logic [7:0] ad, input logic [15:0] wd,
                     input logic oe, input logic il, input logic sl);
    @(negedge clk);
    stall = st; sel = se; loadN = ld; readNotWrite = rw; byteWe = be;
    addr = ad; wrData = wd; outEn = oe; burstInterleave = il; sleepReq = sl;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [16:0] got, input logic [16:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  initial begin
    #100000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #0.5;
    // R1 reset state
    chk("R1 valid/ack", {15'd0, rdValid, sleepAck}, 17'd0);
    cyc(1'b0,1'b1,1'b0,1'b1,2'b00,8'h55,16'h0,1'b1,1'b0,1'b0);
    chk("R1 zero word", {rdValid, rdData}, {1'b1, 16'h0000});

    for (int i = 0; i < NV; i++) begin
      cyc(TBL[i].st, TBL[i].se, TBL[i].ld, TBL[i].rw, TBL[i].be, TBL[i].ad,
          TBL[i].wd, TBL[i].oe, TBL[i].il, 1'b0);
      chk($sformatf("vector %0d", i), {rdValid, rdData}, {TBL[i].ev, TBL[i].ed});
    end

    // R10 sleep gating
    cyc(1'b0,1'b1,1'b0,1'b0,2'b11,8'h30,16'h0,1'b1,1'b0,1'b0);
    cyc(1'b0,1'b0,1'b0,1'b1,2'b00,8'h00,16'h7777,1'b1,1'b0,1'b1);
    chk("R10 no ack with write data pending", {16'd0, sleepAck}, 17'd0);
    cyc(1'b0,1'b1,1'b0,1'b1,2'b00,8'h30,16'h0,1'b1,1'b0,1'b1);
    chk("R10 command blocked", {sleepAck, rdValid, 15'd0}, 17'd0);
    cyc(1'b0,1'b0,1'b0,1'b1,2'b00,8'h00,16'h0,1'b1,1'b0,1'b1);
    chk("R10 ack after drain", {16'd0, sleepAck}, 17'd1);
    cyc(1'b1,1'b0,1'b0,1'b1,2'b00,8'h00,16'h0,1'b1,1'b0,1'b0);
    chk("R7 stall holds sleep", {16'd0, sleepAck}, 17'd1);
    cyc(1'b0,1'b1,1'b0,1'b1,2'b00,8'h30,16'h0,1'b1,1'b0,1'b0);
    chk("R10 exit edge", {sleepAck, rdValid, 15'd0}, 17'd0);
    cyc(1'b0,1'b1,1'b0,1'b1,2'b00,8'h30,16'h0,1'b1,1'b0,1'b0);
    chk("R10 write done before sleep", {rdValid, rdData}, {1'b1, 16'h7777});

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule